// File: doc/BRIEF.md
# Control and Status Register Unit

This block serves the control and status register instructions of a single 32-bit hart. Each request carries a 12-bit register address, the three-bit operation code from the instruction, the 5-bit source field (register index or immediate), the destination register index and the privilege level the hart runs at. One clock later the unit returns the previous contents of the addressed register, a flag that says whether the destination register is to be written, and a flag that marks the access as illegal. The pipeline raises the trap from that flag.

The unit holds three free-running 64-bit counters, each read as two 32-bit halves: a clock counter, a wall-time counter advanced by an external tick, and a retired-instruction counter advanced by a retire pulse. It also answers for a set of fixed identification registers and for a constant ISA description register. Every register it implements is either read-only or ignores writes. The source register value is therefore never needed. Only the source field matters, because that field decides whether an operation counts as a write. Access rights come from the address itself. Bits [9:8] give the lowest privilege allowed, and the value 2'b11 in bits [11:10] marks a register as read-only.

Top module: `csr_unit`

## Requirements
- R1: A request with `req_valid_i` high at a rising edge yields `rsp_valid_o` high with its results during the following cycle. `rsp_valid_o` is low in any cycle that follows an edge with no request, and all response outputs are zero after reset.
- R2: The access is illegal when address bits [9:8], read as a number, exceed `req_priv_i` (0 user, 1 supervisor, 3 machine).
- R3: The operation codes are 1 swap, 2 set bits, 3 clear bits, 5 swap-immediate, 6 set-immediate and 7 clear-immediate. Codes 1 and 5 always count as writes. The other four count as writes only when the source field is non-zero. A write to an address whose bits [11:10] equal 2'b11 is illegal, and a non-writing set or clear on such an address is legal.
- R4: On a legal access `rsp_rdata_o` returns the register's value as it stood at the request edge, and `rsp_wb_en_o` is high exactly when the destination index is non-zero.
- R5: The clock counter starts at zero after reset and advances by one every cycle. Its low half is at 0xC00 and its high half at 0xC80.
- R6: The retired-instruction counter starts at zero and advances by one in each cycle with `retire_i` high. Its halves are at 0xC02 and 0xC82.
- R7: The time counter starts at zero and advances by one in each cycle with `tick_i` high. Its halves are at 0xC01 and 0xC81.
- R8: Addresses 0xF11, 0xF12 and 0xF13 read as zero, and 0xF14 reads as the `HART_ID` parameter.
- R9: Address 0x301 reads as 0x40141100: bit 30 for 32-bit width, and bits 8, 12, 18 and 20 for the base integer set, multiply, supervisor and user support. Writes to it are legal and leave that value unchanged.
- R10: An unimplemented address, or operation code 0 or 4, makes the access illegal. An illegal access returns zero data and never asserts `rsp_wb_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Advances the time counter |
| retire_i | input | 1 | One instruction retired this cycle |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 12 | Register address |
| req_funct3_i | input | 3 | Operation code |
| req_rs1_i | input | 5 | Source register index or immediate |
| req_rd_i | input | 5 | Destination register index |
| req_priv_i | input | 2 | Current privilege level |
| rsp_valid_o | output | 1 | Response present |
| rsp_rdata_o | output | 32 | Previous register value |
| rsp_wb_en_o | output | 1 | Write the destination register |
| rsp_illegal_o | output | 1 | Access is illegal |

## Verification
Every result is due in the cycle after the request edge. This includes the data, the write-back flag and the illegal flag. A counter value read back is the count that stood just before that edge. The bench drives the request half a cycle before the edge and computes the expected counter value from its own model at that moment. It then checks all four response outputs at the next falling edge, one full register stage later. The bench also checks that the valid flag falls in the cycle after a request is withdrawn.

// File: rtl/csr_pkg.sv
package csr_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_SWAP = 3'd1,
        OP_SET  = 3'd2,
        OP_CLR  = 3'd3,
        OP_RSV  = 3'd4,
        OP_SWPI = 3'd5,
        OP_SETI = 3'd6,
        OP_CLRI = 3'd7
    } csr_op_e;

    typedef struct packed {
        logic [11:0] addr;
        csr_op_e     op;
        logic [4:0]  src;
        logic [4:0]  dst;
        logic [1:0]  priv;
    } csr_req_t;

    typedef struct packed {
        logic        valid;
        logic [31:0] rdata;
        logic        wb_en;
        logic        illegal;
    } csr_rsp_t;

    localparam int XLEN      = 32;
    localparam int CNT_W     = 64;
    localparam int NUM_CNT   = 3;

    localparam logic [11:0] A_ISA    = 12'h301;
    localparam logic [11:0] A_VENDOR = 12'hF11;
    localparam logic [11:0] A_ARCH   = 12'hF12;
    localparam logic [11:0] A_IMPL   = 12'hF13;
    localparam logic [11:0] A_HART   = 12'hF14;

    function automatic logic [XLEN-1:0] isa_word();
        logic [XLEN-1:0] w;
        w = '0;
        w[30] = 1'b1;
        w[8]  = 1'b1;
        w[12] = 1'b1;
        w[18] = 1'b1;
        w[20] = 1'b1;
        return w;
    endfunction

    function automatic logic op_known(csr_op_e op);
        return (op != OP_NONE) && (op != OP_RSV);
    endfunction

    function automatic logic op_writes(csr_op_e op, logic [4:0] src);
        case (op)
            OP_SWAP, OP_SWPI:                return 1'b1;
            OP_SET, OP_CLR, OP_SETI, OP_CLRI: return src != 5'd0;
            default:                          return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/csr_counters.sv
module csr_counters
    import csr_pkg::*;
#(
    parameter int N = NUM_CNT,
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      inc,
    output logic [N-1:0][W-1:0] cnt
);

    for (genvar i = 0; i < N; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                cnt[i] <= '0;
            else if (inc[i])
                cnt[i] <= cnt[i] + W'(1);
        end

        // R5 R6 R7: each counter moves by exactly one on its enable
        p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
            inc[i] |=> cnt[i] == $past(cnt[i]) + W'(1));
        // R6 R7: counter holds without enable
        p_cnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
            !inc[i] |=> $stable(cnt[i]));
    end

endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
    import csr_pkg::*;
#(
    parameter int              N       = NUM_CNT,
    parameter int              W       = CNT_W,
    parameter logic [XLEN-1:0] HART_ID = '0
) (
    input  logic [11:0]           addr,
    input  logic [N-1:0][W-1:0]   cnt,
    output logic                  hit,
    output logic [XLEN-1:0]       data
);

    localparam int IDX_W = $clog2(N);

    logic            is_cnt;
    logic [IDX_W-1:0] idx;

    assign idx    = addr[IDX_W-1:0];
    assign is_cnt = (addr[11:8] == 4'hC) && (addr[6:IDX_W] == '0) && (int'(idx) < N);

    always_comb begin
        hit  = 1'b1;
        data = '0;
        if (is_cnt) begin
            data = addr[7] ? cnt[idx][W-1 -: XLEN] : cnt[idx][XLEN-1:0];
        end else begin
            case (addr)
                A_ISA:                      data = isa_word();
                A_VENDOR, A_ARCH, A_IMPL:   data = '0;
                A_HART:                     data = HART_ID;
                default:                    hit  = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/csr_access_chk.sv
module csr_access_chk
    import csr_pkg::*;
(
    input  csr_req_t req,
    input  logic     hit,
    output logic     illegal
);

    logic lvl_bad, ro_bad;

    assign lvl_bad = req.addr[9:8] > req.priv;
    assign ro_bad  = (req.addr[11:10] == 2'b11) && op_writes(req.op, req.src);
    assign illegal = !hit || !op_known(req.op) || lvl_bad || ro_bad;

endmodule

// File: rtl/csr_unit.sv
module csr_unit
    import csr_pkg::*;
#(
    parameter logic [31:0] HART_ID = 32'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        retire_i,
    input  logic        req_valid_i,
    input  logic [11:0] req_addr_i,
    input  logic [2:0]  req_funct3_i,
    input  logic [4:0]  req_rs1_i,
    input  logic [4:0]  req_rd_i,
    input  logic [1:0]  req_priv_i,
    output logic        rsp_valid_o,
    output logic [31:0] rsp_rdata_o,
    output logic        rsp_wb_en_o,
    output logic        rsp_illegal_o
);

    csr_req_t                       req;
    csr_rsp_t                       rsp_q;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;
    logic                           hit, illegal;
    logic [XLEN-1:0]                rdata;

    assign req.addr = req_addr_i;
    assign req.op   = csr_op_e'(req_funct3_i);
    assign req.src  = req_rs1_i;
    assign req.dst  = req_rd_i;
    assign req.priv = req_priv_i;

    // counter index equals address bits [1:0]: cycle, time, retired
    csr_counters #(.N(NUM_CNT), .W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc ({retire_i, tick_i, 1'b1}),
        .cnt (cnt)
    );

    csr_read_mux #(.N(NUM_CNT), .W(CNT_W), .HART_ID(HART_ID)) u_mux (
        .addr (req.addr),
        .cnt  (cnt),
        .hit  (hit),
        .data (rdata)
    );

    csr_access_chk u_chk (
        .req     (req),
        .hit     (hit),
        .illegal (illegal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid   <= req_valid_i;
            rsp_q.illegal <= req_valid_i && illegal;
            rsp_q.wb_en   <= req_valid_i && !illegal && (req.dst != 5'd0);
            rsp_q.rdata   <= (req_valid_i && !illegal) ? rdata : '0;
        end
    end

    assign rsp_valid_o   = rsp_q.valid;
    assign rsp_rdata_o   = rsp_q.rdata;
    assign rsp_wb_en_o   = rsp_q.wb_en;
    assign rsp_illegal_o = rsp_q.illegal;

    // R1: response follows request by one cycle
    p_rsp_follow_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o);
    // R2: privilege level too low is trapped
    p_priv_low_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid_i && (req_addr_i[9:8] > req_priv_i) |=> rsp_illegal_o);
    // R3: swap on a read-only address is trapped
    p_ro_swap_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid_i && (req_addr_i[11:10] == 2'b11) && (req_funct3_i[1:0] == 2'b01)
        |=> rsp_illegal_o);
    // R4: destination zero never writes back
    p_rd_zero_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid_i && (req_rd_i == 5'd0) |=> !rsp_wb_en_o);
    // R10: illegal access has no write-back and zero data
    p_ill_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_illegal_o |-> !rsp_wb_en_o && (rsp_rdata_o == '0));

endmodule

// File: tb/csr_unit_bench.sv
`timescale 1ns/1ps
module csr_unit_bench;

    localparam logic [31:0] HART = 32'h0000_0005;
    localparam logic [31:0] ISA  = 32'h4014_1100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0, retire_i = 1'b0, req_valid_i = 1'b0;
    logic [11:0] req_addr_i = '0;
    logic [2:0]  req_funct3_i = '0;
    logic [4:0]  req_rs1_i = '0, req_rd_i = '0;
    logic [1:0]  req_priv_i = '0;
    logic        rsp_valid_o, rsp_wb_en_o, rsp_illegal_o;
    logic [31:0] rsp_rdata_o;

    int total = 0;
    int bad   = 0;

    logic [63:0] m_cyc, m_tim, m_ins;

    always #4 clk = ~clk;

    csr_unit #(.HART_ID(HART)) u_csr_unit (
        .clk, .rst, .tick_i, .retire_i, .req_valid_i, .req_addr_i,
        .req_funct3_i, .req_rs1_i, .req_rd_i, .req_priv_i,
        .rsp_valid_o, .rsp_rdata_o, .rsp_wb_en_o, .rsp_illegal_o
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cyc <= '0; m_tim <= '0; m_ins <= '0;
        end else begin
            m_cyc <= m_cyc + 64'd1;
            if (tick_i)   m_tim <= m_tim + 64'd1;
            if (retire_i) m_ins <= m_ins + 64'd1;
        end
    end

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void ref_calc(input logic [11:0] a, input logic [2:0] f3,
                                     input logic [4:0] rs1, input logic [4:0] rd,
                                     input logic [1:0] pv, output logic ill,
                                     output logic [31:0] dat, output logic wb);
        logic hit, wr, known;
        hit = 1'b1;
        dat = '0;
        case (a)
            12'hC00: dat = m_cyc[31:0];
            12'hC80: dat = m_cyc[63:32];
            12'hC01: dat = m_tim[31:0];
            12'hC81: dat = m_tim[63:32];
            12'hC02: dat = m_ins[31:0];
            12'hC82: dat = m_ins[63:32];
            12'h301: dat = ISA;
            12'hF11, 12'hF12, 12'hF13: dat = '0;
            12'hF14: dat = HART;
            default: hit = 1'b0;
        endcase
        known = (f3 != 3'd0) && (f3 != 3'd4);
        wr = (f3 == 3'd1) || (f3 == 3'd5) || (known && rs1 != 5'd0);
        ill = !hit || !known || (a[9:8] > pv) || (a[11:10] == 2'b11 && wr);
        if (ill) dat = '0;
        wb = !ill && (rd != 5'd0);
    endfunction

    // drive at negedge, result checked at the following negedge
    task automatic issue(string tag, logic [11:0] a, logic [2:0] f3,
                         logic [4:0] rs1, logic [4:0] rd, logic [1:0] pv);
        logic ill, wb;
        logic [31:0] dat;
        req_valid_i = 1'b1; req_addr_i = a; req_funct3_i = f3;
        req_rs1_i = rs1; req_rd_i = rd; req_priv_i = pv;
        ref_calc(a, f3, rs1, rd, pv, ill, dat, wb);
        @(negedge clk);
        req_valid_i = 1'b0;
        check(tag, "valid",   {31'd0, rsp_valid_o},   32'd1);
        check(tag, "illegal", {31'd0, rsp_illegal_o}, {31'd0, ill});
        check(tag, "rdata",   rsp_rdata_o,            dat);
        check(tag, "wb_en",   {31'd0, rsp_wb_en_o},   {31'd0, wb});
    endtask

    task automatic pulses(int n, logic t, logic r);
        for (int i = 0; i < n; i++) begin
            tick_i = t; retire_i = r;
            @(negedge clk);
        end
        tick_i = 1'b0; retire_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [11:0] pool [12];
        void'($urandom(32'd1234));
        pool = '{12'hC00, 12'hC80, 12'hC01, 12'hC81, 12'hC02, 12'hC82,
                 12'h301, 12'hF11, 12'hF12, 12'hF13, 12'hF14, 12'h340};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "valid after reset", {31'd0, rsp_valid_o}, 32'd0);
        check("R1", "data after reset",  rsp_rdata_o, 32'd0);
        check("R1", "wb after reset",    {31'd0, rsp_wb_en_o}, 32'd0);
        repeat (3) @(negedge clk);
        // R5: clock counter halves
        issue("R5", 12'hC00, 3'd2, 5'd0, 5'd1, 2'd0);
        issue("R5", 12'hC80, 3'd2, 5'd0, 5'd1, 2'd0);
        // R6: retired counter
        pulses(7, 1'b0, 1'b1);
        issue("R6", 12'hC02, 3'd6, 5'd0, 5'd3, 2'd0);
        issue("R6", 12'hC82, 3'd3, 5'd0, 5'd3, 2'd1);
        // R7: time counter
        pulses(5, 1'b1, 1'b0);
        issue("R7", 12'hC01, 3'd7, 5'd0, 5'd9, 2'd3);
        issue("R7", 12'hC81, 3'd2, 5'd0, 5'd9, 2'd3);
        // R8: identification registers
        issue("R8", 12'hF14, 3'd2, 5'd0, 5'd4, 2'd3);
        issue("R8", 12'hF12, 3'd2, 5'd0, 5'd4, 2'd3);
        // R9: write to ISA register is legal and ignored
        issue("R9", 12'h301, 3'd1, 5'd8, 5'd2, 2'd3);
        issue("R9", 12'h301, 3'd3, 5'd31, 5'd2, 2'd3);
        issue("R9", 12'h301, 3'd2, 5'd0, 5'd2, 2'd3);
        // R2: privilege too low
        issue("R2", 12'h301, 3'd2, 5'd0, 5'd2, 2'd1);
        issue("R2", 12'hF14, 3'd2, 5'd0, 5'd2, 2'd0);
        // R3: writes on read-only addresses
        issue("R3", 12'hC00, 3'd1, 5'd0, 5'd2, 2'd3);
        issue("R3", 12'hC00, 3'd6, 5'd3, 5'd2, 2'd3);
        issue("R3", 12'hF11, 3'd3, 5'd0, 5'd2, 2'd3);
        // R4: destination zero
        issue("R4", 12'h301, 3'd5, 5'd1, 5'd0, 2'd3);
        issue("R4", 12'hC02, 3'd2, 5'd0, 5'd0, 2'd0);
        // R10: unimplemented address and reserved codes
        issue("R10", 12'h123, 3'd2, 5'd0, 5'd5, 2'd3);
        issue("R10", 12'hC00, 3'd4, 5'd0, 5'd5, 2'd3);
        issue("R10", 12'hF11, 3'd0, 5'd0, 5'd5, 2'd3);
        // R1: valid drops with no request
        @(negedge clk);
        check("R1", "valid idle", {31'd0, rsp_valid_o}, 32'd0);
        // random mix, all requirements
        for (int k = 0; k < 400; k++) begin
            logic [11:0] a;
            a = ($urandom % 4 == 0) ? 12'($urandom) : pool[$urandom % 12];
            tick_i = 1'($urandom); retire_i = 1'($urandom);
            issue("R4", a, 3'($urandom), 5'($urandom % 3 == 0 ? 0 : $urandom),
                  5'($urandom % 4 == 0 ? 0 : $urandom), 2'($urandom));
        end
        tick_i = 1'b0; retire_i = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule